// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits between instruction decode and the data memory port of a 16-bit processor. It takes one 16-bit instruction word per cycle, reads up to two registers through read ports that the register file answers in the same cycle, and turns the instruction into a memory request. A request consists of an address, a read or write strobe, store data and the destination tag of a load. Where the addressing mode needs it, the unit also produces register writes on two write ports. The memory, instruction fetch and the arithmetic unit are outside the block.

Four opcode groups address memory relative to a base register, using an unsigned 8-bit displacement. The base is either register 0, which holds the program counter already advanced past the current instruction, or register 2, the stack pointer. A fifth group covers register-indirect loads and stores with plain, post-increment, pre-increment, post-decrement and pre-decrement forms. The same group also holds a register copy and a register swap. Decoding and address arithmetic are combinational. Every result is captured in one register stage, so outputs describe the instruction presented one clock earlier.

Top module: `lsagu`

## Requirements
- R1: While reset is asserted, and directly after it, every strobe and write enable is low and every address, data and tag output is zero, even if a valid instruction is presented.
- R2: Outputs appear exactly one clock after the instruction is sampled. A cycle with the valid input low gives all-zero outputs in the next cycle. Address, store data, load tag and write-port data are also zero whenever their strobe or enable is low.
- R3: Bits 15:12 pick the group. Group 0 loads from register 0 plus displacement, group 1 loads from register 2 plus displacement, group 2 stores to register 0 plus displacement, and group 3 stores to register 2 plus displacement. The displacement is bits 7:0, zero-extended, and the sum wraps modulo 2^16. These groups write no register. Groups 5 to 15 produce no request and no register write.
- R4: A relative store takes its data from the register named in bits 11:8. A relative load reports bits 11:8 as its load tag.
- R5: In group 4, sub-codes 0 to 4 in bits 3:0 are loads: plain, post-increment, pre-increment, post-decrement and pre-decrement. The base register is in bits 7:4 and the load tag is bits 11:8.
- R6: In group 4, sub-codes 8 to 12 are stores in the same five-mode order. The base register is in bits 11:8 and the data register in bits 7:4.
- R7: Pre-modify modes use the updated base as the address. Post-modify modes use the old base. Both write the updated base (plus or minus 1, modulo 2^16) to the base register on write port 0. The plain mode writes nothing.
- R8: Sub-code 6 writes the value of the register in bits 7:4 into the register in bits 11:8 on write port 0, with no memory strobe.
- R9: Sub-code 14 swaps two registers. Write port 0 writes the bits 7:4 register with the old value of the bits 11:8 register, and write port 1 writes the bits 11:8 register with the old value of the bits 7:4 register. No memory strobe is raised.
- R10: Sub-codes 5, 7, 13 and 15 of group 4 raise no strobe and no register write.
- R11: A load raises only the read strobe and a store raises only the write strobe. The two strobes are never high together.
- R12: An auto-modify store whose data register is also its base register stores the base value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | Instruction word is valid this cycle |
| insn | input | 16 | Instruction word |
| rf_sel_a | output | 4 | Register index for read port A (base or copy source) |
| rf_val_a | input | DATA_W | Value of the register at rf_sel_a, same cycle |
| rf_sel_b | output | 4 | Register index for read port B (store data or swap partner) |
| rf_val_b | input | DATA_W | Value of the register at rf_sel_b, same cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | DATA_W | Memory address |
| mem_wdata | output | DATA_W | Store data |
| ld_tag | output | 4 | Destination register of the load |
| wp0_en | output | 1 | Write port 0 enable |
| wp0_sel | output | 4 | Write port 0 register index |
| wp0_val | output | DATA_W | Write port 0 data |
| wp1_en | output | 1 | Write port 1 enable |
| wp1_sel | output | 4 | Write port 1 register index |
| wp1_val | output | DATA_W | Write port 1 data |

## Verification
The unit holds no state beyond its output stage, so any wrong internal value reaches the ports exactly one cycle after the instruction that caused it. Examples are a mis-decoded field, a swapped read-port choice, or an increment applied before or after the wrong point. The faulty value shows up as a wrong address, strobe, tag or write-port field, and the next instruction overwrites it. Every output field is therefore compared one cycle after each instruction. The patterns are chosen so that each mode gives a value distinct from its neighbours: old versus updated base, plus versus minus, and the bits 7:4 register versus the bits 11:8 register. Wrap-around at 0xFFFF and 0x0000 is also covered.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

  localparam int INSN_W = 16;
  localparam int RSEL_W = 4;

  localparam logic [3:0] GRP_LD_PC = 4'h0;
  localparam logic [3:0] GRP_LD_SP = 4'h1;
  localparam logic [3:0] GRP_ST_PC = 4'h2;
  localparam logic [3:0] GRP_ST_SP = 4'h3;
  localparam logic [3:0] GRP_INDIR = 4'h4;

  localparam logic [RSEL_W-1:0] REG_PC = 4'd0;
  localparam logic [RSEL_W-1:0] REG_SP = 4'd2;

  typedef enum logic [2:0] {
    OP_IDLE, OP_REL_LD, OP_REL_ST, OP_IND_LD, OP_IND_ST, OP_MOVE, OP_SWAP
  } op_e;

  typedef enum logic [2:0] {
    AM_FLAT, AM_POST_INC, AM_PRE_INC, AM_POST_DEC, AM_PRE_DEC
  } amode_e;

  typedef struct packed {
    op_e               op;
    amode_e            am;
    logic [RSEL_W-1:0] sel_a;
    logic [RSEL_W-1:0] sel_b;
    logic [RSEL_W-1:0] dst;
  } dctl_t;

  // low three bits of an indirect sub-code map onto the five addressing forms
  function automatic amode_e amode_of(input logic [2:0] code);
    case (code)
      3'd1:    return AM_POST_INC;
      3'd2:    return AM_PRE_INC;
      3'd3:    return AM_POST_DEC;
      3'd4:    return AM_PRE_DEC;
      default: return AM_FLAT;
    endcase
  endfunction

endpackage

// File: rtl/lsagu_decode.sv
module lsagu_decode
  import lsagu_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic              vld,
  input  logic [INSN_W-1:0] insn,
  output dctl_t             ctl,
  output logic [OFF_W-1:0]  off
);

  logic [3:0]        grp;
  logic [3:0]        sub;
  logic [RSEL_W-1:0] fld_lo;
  logic [RSEL_W-1:0] fld_hi;

  assign grp    = insn[15:12];
  assign sub    = insn[3:0];
  assign fld_lo = insn[7:4];
  assign fld_hi = insn[11:8];
  assign off    = insn[OFF_W-1:0];

  always_comb begin
    ctl       = '0;
    ctl.op    = OP_IDLE;
    ctl.am    = AM_FLAT;
    if (vld) begin
      case (grp)
        GRP_LD_PC, GRP_LD_SP: begin
          ctl.op    = OP_REL_LD;
          ctl.sel_a = (grp == GRP_LD_SP) ? REG_SP : REG_PC;
          ctl.dst   = fld_hi;
        end
        GRP_ST_PC, GRP_ST_SP: begin
          ctl.op    = OP_REL_ST;
          ctl.sel_a = (grp == GRP_ST_SP) ? REG_SP : REG_PC;
          ctl.sel_b = fld_hi;
        end
        GRP_INDIR: begin
          case (sub)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4: begin
              ctl.op    = OP_IND_LD;
              ctl.am    = amode_of(sub[2:0]);
              ctl.sel_a = fld_lo;
              ctl.dst   = fld_hi;
            end
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC: begin
              ctl.op    = OP_IND_ST;
              ctl.am    = amode_of(sub[2:0]);
              ctl.sel_a = fld_hi;
              ctl.sel_b = fld_lo;
            end
            4'h6: begin
              ctl.op    = OP_MOVE;
              ctl.sel_a = fld_lo;
              ctl.dst   = fld_hi;
            end
            4'hE: begin
              ctl.op    = OP_SWAP;
              ctl.sel_a = fld_lo;
              ctl.sel_b = fld_hi;
            end
            default: ctl.op = OP_IDLE;
          endcase
        end
        default: ctl.op = OP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsagu_addr.sv
module lsagu_addr
  import lsagu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8
) (
  input  op_e               op,
  input  amode_e            am,
  input  logic [DATA_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] ea,
  output logic [DATA_W-1:0] upd_base,
  output logic              base_wb
);

  localparam int PAD_W = DATA_W - OFF_W;

  function automatic logic [DATA_W-1:0] disp_add(input logic [DATA_W-1:0] b,
                                                 input logic [OFF_W-1:0]  d);
    return b + {{PAD_W{1'b0}}, d};
  endfunction

  function automatic logic [DATA_W-1:0] step_base(input logic [DATA_W-1:0] b,
                                                  input amode_e m);
    case (m)
      AM_POST_INC, AM_PRE_INC: return b + DATA_W'(1);
      AM_POST_DEC, AM_PRE_DEC: return b - DATA_W'(1);
      default:                 return b;
    endcase
  endfunction

  function automatic logic is_pre(input amode_e m);
    return (m == AM_PRE_INC) || (m == AM_PRE_DEC);
  endfunction

  logic indirect;
  assign indirect = (op == OP_IND_LD) || (op == OP_IND_ST);

  always_comb begin
    upd_base = step_base(base, am);
    base_wb  = indirect && (am != AM_FLAT);
    if (indirect) ea = is_pre(am) ? upd_base : base;
    else          ea = disp_add(base, off);
  end

endmodule

// File: rtl/lsagu_oreg.sv
module lsagu_oreg
  import lsagu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NWP    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              n_rd,
  input  logic                              n_wr,
  input  logic [DATA_W-1:0]                 n_addr,
  input  logic [DATA_W-1:0]                 n_wdata,
  input  logic [RSEL_W-1:0]                 n_tag,
  input  logic [NWP-1:0]                    n_wen,
  input  logic [NWP-1:0][RSEL_W-1:0]        n_wsel,
  input  logic [NWP-1:0][DATA_W-1:0]        n_wval,
  output logic                              q_rd,
  output logic                              q_wr,
  output logic [DATA_W-1:0]                 q_addr,
  output logic [DATA_W-1:0]                 q_wdata,
  output logic [RSEL_W-1:0]                 q_tag,
  output logic [NWP-1:0]                    q_wen,
  output logic [NWP-1:0][RSEL_W-1:0]        q_wsel,
  output logic [NWP-1:0][DATA_W-1:0]        q_wval
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rd    <= 1'b0;
      q_wr    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_tag   <= '0;
    end else begin
      q_rd    <= n_rd;
      q_wr    <= n_wr;
      q_addr  <= n_addr;
      q_wdata <= n_wdata;
      q_tag   <= n_tag;
    end
  end

  for (genvar g = 0; g < NWP; g++) begin : g_wp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_wen[g]  <= 1'b0;
        q_wsel[g] <= '0;
        q_wval[g] <= '0;
      end else begin
        q_wen[g]  <= n_wen[g];
        q_wsel[g] <= n_wsel[g];
        q_wval[g] <= n_wval[g];
      end
    end
  end

endmodule

// File: rtl/lsagu.sv
module lsagu
  import lsagu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_vld,
  input  logic [15:0]       insn,
  output logic [3:0]        rf_sel_a,
  input  logic [DATA_W-1:0] rf_val_a,
  output logic [3:0]        rf_sel_b,
  input  logic [DATA_W-1:0] rf_val_b,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [3:0]        ld_tag,
  output logic              wp0_en,
  output logic [3:0]        wp0_sel,
  output logic [DATA_W-1:0] wp0_val,
  output logic              wp1_en,
  output logic [3:0]        wp1_sel,
  output logic [DATA_W-1:0] wp1_val
);

  localparam int NWP = 2;

  dctl_t             ctl;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] ea;
  logic [DATA_W-1:0] upd_base;
  logic              base_wb;

  // named decode events, observed by the bound checker
  logic is_load;
  logic is_store;

  logic [DATA_W-1:0]          n_addr;
  logic [DATA_W-1:0]          n_wdata;
  logic [RSEL_W-1:0]          n_tag;
  logic [NWP-1:0]             n_wen;
  logic [NWP-1:0][RSEL_W-1:0] n_wsel;
  logic [NWP-1:0][DATA_W-1:0] n_wval;

  logic [NWP-1:0]             q_wen;
  logic [NWP-1:0][RSEL_W-1:0] q_wsel;
  logic [NWP-1:0][DATA_W-1:0] q_wval;

  lsagu_decode #(.OFF_W(OFF_W)) u_dec (
    .vld  (insn_vld),
    .insn (insn),
    .ctl  (ctl),
    .off  (off)
  );

  assign rf_sel_a = ctl.sel_a;
  assign rf_sel_b = ctl.sel_b;

  lsagu_addr #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_addr (
    .op       (ctl.op),
    .am       (ctl.am),
    .base     (rf_val_a),
    .off      (off),
    .ea       (ea),
    .upd_base (upd_base),
    .base_wb  (base_wb)
  );

  assign is_load  = (ctl.op == OP_REL_LD) || (ctl.op == OP_IND_LD);
  assign is_store = (ctl.op == OP_REL_ST) || (ctl.op == OP_IND_ST);

  always_comb begin
    n_addr  = (is_load || is_store) ? ea : '0;
    n_wdata = is_store ? rf_val_b : '0;
    n_tag   = is_load ? ctl.dst : '0;
    n_wen   = '0;
    n_wsel  = '0;
    n_wval  = '0;
    case (ctl.op)
      OP_IND_LD, OP_IND_ST: begin
        if (base_wb) begin
          n_wen[0]  = 1'b1;
          n_wsel[0] = ctl.sel_a;
          n_wval[0] = upd_base;
        end
      end
      OP_MOVE: begin
        n_wen[0]  = 1'b1;
        n_wsel[0] = ctl.dst;
        n_wval[0] = rf_val_a;
      end
      OP_SWAP: begin
        n_wen     = '1;
        n_wsel[0] = ctl.sel_a;
        n_wval[0] = rf_val_b;
        n_wsel[1] = ctl.sel_b;
        n_wval[1] = rf_val_a;
      end
      default: ;
    endcase
  end

  lsagu_oreg #(.DATA_W(DATA_W), .NWP(NWP)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .n_rd    (is_load),
    .n_wr    (is_store),
    .n_addr  (n_addr),
    .n_wdata (n_wdata),
    .n_tag   (n_tag),
    .n_wen   (n_wen),
    .n_wsel  (n_wsel),
    .n_wval  (n_wval),
    .q_rd    (mem_rd),
    .q_wr    (mem_wr),
    .q_addr  (mem_addr),
    .q_wdata (mem_wdata),
    .q_tag   (ld_tag),
    .q_wen   (q_wen),
    .q_wsel  (q_wsel),
    .q_wval  (q_wval)
  );

  assign wp0_en  = q_wen[0];
  assign wp0_sel = q_wsel[0];
  assign wp0_val = q_wval[0];
  assign wp1_en  = q_wen[1];
  assign wp1_sel = q_wsel[1];
  assign wp1_val = q_wval[1];

endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_vld,
  input logic [15:0]       insn,
  input logic [DATA_W-1:0] rf_val_a,
  input logic [DATA_W-1:0] rf_val_b,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_addr,
  input logic              wp0_en,
  input logic [DATA_W-1:0] wp0_val,
  input logic              wp1_en,
  input logic [DATA_W-1:0] wp1_val,
  input logic              is_load,
  input logic              is_store
);

  logic grp_ind;
  assign grp_ind = insn_vld && (insn[15:12] == 4'h4);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> (mem_rd && !mem_wr));

  // R11
  store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> (mem_wr && !mem_rd && !wp1_en));

  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> (!mem_rd && !mem_wr && !wp0_en && !wp1_en));

  // R3
  rel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && insn[15:14] == 2'b00)
    |=> (mem_addr == DATA_W'($past(rf_val_a) + DATA_W'($past(insn[7:0])))
         && !wp0_en && !wp1_en));

  // R10
  undef_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_ind && insn[2] && insn[0])
    |=> (!mem_rd && !mem_wr && !wp0_en && !wp1_en));

  // R7
  post_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_ind && (insn[2:0] == 3'd1 || insn[2:0] == 3'd3))
    |=> (wp0_en && mem_addr == $past(rf_val_a)
         && wp0_val == ($past(insn[1]) ? DATA_W'(mem_addr - DATA_W'(1))
                                       : DATA_W'(mem_addr + DATA_W'(1)))));

  // R7
  pre_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_ind && (insn[2:0] == 3'd2 || insn[2:0] == 3'd4))
    |=> (wp0_en && wp0_val == mem_addr
         && mem_addr == ($past(insn[2]) ? DATA_W'($past(rf_val_a) - DATA_W'(1))
                                        : DATA_W'($past(rf_val_a) + DATA_W'(1)))));

  // R9
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_ind && insn[3:0] == 4'hE)
    |=> (wp0_en && wp1_en && !mem_rd && !mem_wr
         && wp0_val == $past(rf_val_b) && wp1_val == $past(rf_val_a)));

endmodule

bind lsagu lsagu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .insn_vld (insn_vld),
  .insn     (insn),
  .rf_val_a (rf_val_a),
  .rf_val_b (rf_val_b),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .wp0_en   (wp0_en),
  .wp0_val  (wp0_val),
  .wp1_en   (wp1_en),
  .wp1_val  (wp1_val),
  .is_load  (is_load),
  .is_store (is_store)
);

// File: tb/lsagu_test.sv
module lsagu_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_vld = 1'b0;
  logic [15:0] insn = '0;
  logic [3:0]  rf_sel_a, rf_sel_b;
  logic [15:0] rf_val_a, rf_val_b;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata;
  logic [3:0]  ld_tag;
  logic        wp0_en, wp1_en;
  logic [3:0]  wp0_sel, wp1_sel;
  logic [15:0] wp0_val, wp1_val;

  logic [15:0] rf [16];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    logic        rd, wr;
    logic [15:0] addr, wdata;
    logic [3:0]  tag;
    logic        e0, e1;
    logic [3:0]  s0, s1;
    logic [15:0] d0, d1;
  } exp_t;

  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  assign rf_val_a = rf[rf_sel_a];
  assign rf_val_b = rf[rf_sel_b];

  lsagu uut (
    .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn),
    .rf_sel_a(rf_sel_a), .rf_val_a(rf_val_a),
    .rf_sel_b(rf_sel_b), .rf_val_b(rf_val_b),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ld_tag(ld_tag),
    .wp0_en(wp0_en), .wp0_sel(wp0_sel), .wp0_val(wp0_val),
    .wp1_en(wp1_en), .wp1_sel(wp1_sel), .wp1_val(wp1_val)
  );

  // reference model written from the requirements
  function automatic exp_t model(input logic v, input logic [15:0] w, input string req);
    exp_t e;
    logic [3:0]  hi, lo, x, y, bsel, dsel;
    logic [2:0]  kind;
    logic [15:0] old, nb;
    e = '{req: req, rd: 0, wr: 0, addr: 0, wdata: 0, tag: 0,
          e0: 0, e1: 0, s0: 0, s1: 0, d0: 0, d1: 0};
    hi = w[15:12]; lo = w[3:0]; x = w[11:8]; y = w[7:4];
    if (!v) return e;
    if (hi < 4) begin
      old    = rf[hi[0] ? 4'd2 : 4'd0];
      e.addr = old + {8'h00, w[7:0]};
      if (hi[1]) begin e.wr = 1; e.wdata = rf[x]; end
      else       begin e.rd = 1; e.tag = x; end
    end else if (hi == 4) begin
      if (lo <= 4 || (lo >= 8 && lo <= 12)) begin
        bsel = lo[3] ? x : y;
        dsel = lo[3] ? y : x;
        kind = lo[2:0];
        old  = rf[bsel];
        nb   = (kind == 1 || kind == 2) ? old + 16'd1 :
               (kind == 3 || kind == 4) ? old - 16'd1 : old;
        e.addr = (kind == 2 || kind == 4) ? nb : old;
        if (kind != 0) begin e.e0 = 1; e.s0 = bsel; e.d0 = nb; end
        if (lo[3]) begin e.wr = 1; e.wdata = rf[dsel]; end
        else       begin e.rd = 1; e.tag = dsel; end
      end else if (lo == 6) begin
        e.e0 = 1; e.s0 = x; e.d0 = rf[y];
      end else if (lo == 14) begin
        e.e0 = 1; e.s0 = y; e.d0 = rf[x];
        e.e1 = 1; e.s1 = x; e.d1 = rf[y];
      end
    end
    return e;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: called just after a falling edge, pushes the expected result
  task automatic send(input logic v, input logic [15:0] w, input string req);
    insn_vld = v;
    insn     = w;
    sb.push_back(model(v, w, req));
  endtask

  task automatic go(input logic [15:0] w, input string req);
    tick();
    send(1'b1, w, req);
  endtask

  // monitor: compares one cycle after each driven instruction
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (mem_rd !== e.rd || mem_wr !== e.wr || mem_addr !== e.addr ||
          mem_wdata !== e.wdata || ld_tag !== e.tag ||
          wp0_en !== e.e0 || wp0_sel !== e.s0 || wp0_val !== e.d0 ||
          wp1_en !== e.e1 || wp1_sel !== e.s1 || wp1_val !== e.d1) begin
        fails++;
        $display("FAIL %s: got rd=%0b wr=%0b a=%h wd=%h t=%0d w0=%0b/%0d/%h w1=%0b/%0d/%h exp rd=%0b wr=%0b a=%h wd=%h t=%0d w0=%0b/%0d/%h w1=%0b/%0d/%h",
                 e.req, mem_rd, mem_wr, mem_addr, mem_wdata, ld_tag,
                 wp0_en, wp0_sel, wp0_val, wp1_en, wp1_sel, wp1_val,
                 e.rd, e.wr, e.addr, e.wdata, e.tag,
                 e.e0, e.s0, e.d0, e.e1, e.s1, e.d1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 16'h1100 + 16'(i * 16'h0111);
    // R1: valid instruction held during reset must not reach the outputs
    insn_vld = 1'b1; insn = 16'h4339;
    repeat (3) tick();
    checks++;
    if (mem_rd || mem_wr || wp0_en || wp1_en || mem_addr != 0 || mem_wdata != 0 ||
        ld_tag != 0 || wp0_val != 0 || wp1_val != 0) begin
      fails++;
      $display("FAIL R1: got rd=%0b wr=%0b a=%h w0=%0b expected all zero",
               mem_rd, mem_wr, mem_addr, wp0_en);
    end
    insn_vld = 1'b0;
    rst_n = 1'b1;
    tick();
    checks++;
    if (mem_rd || mem_wr || wp0_en || wp1_en || mem_addr != 0) begin
      fails++;
      $display("FAIL R1: got rd=%0b wr=%0b a=%h after release expected zero",
               mem_rd, mem_wr, mem_addr);
    end

    // R3/R4: relative forms
    rf[0] = 16'h1000; rf[2] = 16'hFFF0;
    go(16'h0534, "R3 ld pc rel");
    go(16'h17FF, "R3 ld sp rel");
    tick(); rf[2] = 16'hFFF0; send(1'b1, 16'h1920, "R3 ld sp wrap");
    go(16'h2580, "R4 st pc rel data");
    go(16'h3201, "R4 st sp rel own sp");
    // R3: other groups idle
    go(16'h5123, "R3 grp5 idle");
    go(16'h7ABC, "R3 grp7 idle");
    go(16'hF000, "R3 grp15 idle");
    // R2: valid low with a legal word
    tick(); send(1'b0, 16'h0012, "R2 vld low");

    // R5: indirect loads
    rf[6] = 16'h2000;
    go(16'h4360, "R5 ld flat");
    go(16'h4361, "R5 R7 ld post inc");
    go(16'h4362, "R5 R7 ld pre inc");
    go(16'h4363, "R5 R7 ld post dec");
    go(16'h4364, "R5 R7 ld pre dec");
    // R6: indirect stores
    rf[9] = 16'h3000; rf[4] = 16'hBEEF;
    go(16'h4948, "R6 st flat");
    go(16'h4949, "R6 R7 st post inc");
    go(16'h494A, "R6 R7 st pre inc");
    go(16'h494B, "R6 R7 st post dec");
    go(16'h494C, "R6 R7 st pre dec");
    // R7: wrap at the ends of the range
    tick(); rf[5] = 16'hFFFF; send(1'b1, 16'h4152, "R7 pre inc wrap");
    tick(); rf[5] = 16'h0000; send(1'b1, 16'h4154, "R7 pre dec wrap");
    tick(); rf[5] = 16'h0000; send(1'b1, 16'h4153, "R7 post dec wrap");
    // R12: store whose data register is the base
    tick(); rf[3] = 16'h4444; send(1'b1, 16'h4339, "R12 st base eq data");
    // R8: move
    rf[7] = 16'h7777; rf[10] = 16'hAAAA;
    go(16'h4A76, "R8 move");
    // R9: swap, including same register twice
    go(16'h4A7E, "R9 swap");
    go(16'h477E, "R9 swap self");
    // R10: undefined indirect sub-codes
    go(16'h4125, "R10 sub5");
    go(16'h4127, "R10 sub7");
    go(16'h412D, "R10 sub13");
    go(16'h412F, "R10 sub15");
    // R11: load then store back to back
    go(16'h4A90, "R11 load");
    go(16'h4A98, "R11 store");
    tick(); send(1'b0, 16'h0000, "R2 drain");
    tick(); send(1'b0, 16'h0000, "R2 drain");
    while (sb.size() > 0) tick();
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule